// File: doc/BRIEF.md
# Vector Element Widening Unit

This unit takes one 128-bit source vector and produces a 128-bit result whose elements are twice as wide as the source elements. Two widening operations take half of the source. The "high" form widens the elements in the more significant 64 bits, and the "low" form widens those in the less significant 64 bits. Each widened element is filled with zeros or with copies of its sign bit, as a logical/arithmetic flag selects. A third operation takes the least significant element of each 64-bit lane and sign-extends it to fill that whole lane.

The datapath is combinational. The result and an exception flag are captured in one output register, so a request presented before a rising edge appears at the ports after that edge. The flag is raised when the source element size code is not supported or when the operation code is the reserved value. While the flag is high, the result reads as zero.

Top module: `vec_widen_unit`

## Requirements
- R1: While `rst_n` is low, `result` is all zeros and `spec_exc` is 0.
- R2: `result` and `spec_exc` reflect the inputs sampled at the previous rising clock edge. Before that edge they keep their old values.
- R3: `elem_sz` selects the source element width: 0 means 8 bits, 1 means 16 bits and 2 means 32 bits. The result element width is twice the source width.
- R4: With `op` = 0 (widen high), result element d takes source element d. Element 0 is the most significant element, so source element i occupies bits [127-i*W -: W].
- R5: With `op` = 1 (widen low), result element d takes source element d + N/2, where N = 128/W is the number of source elements.
- R6: For `op` 0 and 1, `zext` = 1 fills the upper half of each result element with zeros. `zext` = 0 fills it with copies of the source element's most significant bit.
- R7: With `op` = 2 (lane sign-extend), result bits [127:64] hold source bits [64+W-1:64] sign-extended to 64 bits. Result bits [63:0] hold source bits [W-1:0] sign-extended to 64 bits. `zext` has no effect on this operation.
- R8: `elem_sz` = 3 raises `spec_exc` for every operation.
- R9: `op` = 3 is reserved and raises `spec_exc` for every element size.
- R10: Whenever `spec_exc` is 1, `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 128 | Source vector; element 0 is in the most significant bits |
| op | input | 2 | 0 widen high, 1 widen low, 2 lane sign-extend, 3 reserved |
| zext | input | 1 | 1 zero-extends, 0 sign-extends (widen operations only) |
| elem_sz | input | 2 | Source element size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is invalid |
| result | output | 128 | Widened result, registered |
| spec_exc | output | 1 | Specification exception, registered |

## Verification
The only state is the output register, so any defect shows on the ports in the cycle right after the request that triggers it. A swapped half or a wrong element index moves data between element slots. A wrong extension source corrupts only the upper half of each result element. Because of this, the expected vectors use element values that differ from each other and have mixed sign bits. A wrong exception decode shows as a flag that is missing or spurious, or as non-zero data beside a raised flag, on the next cycle.

// File: rtl/vec_widen_pkg.sv
package vec_widen_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned NUM_SZ = 3;

  typedef enum logic [1:0] {
    OP_WIDEN_HI = 2'd0,
    OP_WIDEN_LO = 2'd1,
    OP_LANE_SX  = 2'd2,
    OP_RSVD     = 2'd3
  } widen_op_e;
endpackage

// File: rtl/vec_half_widen.sv
module vec_half_widen #(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned SRC_W  = 8
) (
  input  logic [HALF_W-1:0]   half_i,
  input  logic                zext_i,
  output logic [2*HALF_W-1:0] wide_o
);
  localparam int unsigned NELEM = HALF_W / SRC_W;
  localparam int unsigned DST_W = 2 * SRC_W;

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    logic [SRC_W-1:0] elem;
    logic             fill;
    assign elem = half_i[HALF_W-1-e*SRC_W -: SRC_W];
    assign fill = ~zext_i & elem[SRC_W-1];
    assign wide_o[2*HALF_W-1-e*DST_W -: DST_W] = {{SRC_W{fill}}, elem};
  end
endmodule

// File: rtl/vec_lane_sext.sv
module vec_lane_sext #(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned LANE_W = 64
) (
  input  logic [SRC_W-1:0]  elem_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int unsigned EXT_W = LANE_W - SRC_W;
  assign lane_o = {{EXT_W{elem_i[SRC_W-1]}}, elem_i};
endmodule

// File: rtl/vec_widen_unit.sv
module vec_widen_unit
  import vec_widen_pkg::*;
#(
  parameter int unsigned VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] src,
  input  logic [1:0]    op,
  input  logic          zext,
  input  logic [1:0]    elem_sz,
  output logic [VW-1:0] result,
  output logic          spec_exc
);
  localparam int unsigned HALF_W = VW / 2;
  localparam int unsigned LANES  = VW / LANE_W;

  logic [VW-1:0] hi_res [NUM_SZ];
  logic [VW-1:0] lo_res [NUM_SZ];
  logic [VW-1:0] sx_res [NUM_SZ];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    localparam int unsigned SW = 8 << s;

    vec_half_widen #(.HALF_W(HALF_W), .SRC_W(SW)) u_hi (
      .half_i (src[VW-1:HALF_W]),
      .zext_i (zext),
      .wide_o (hi_res[s])
    );

    vec_half_widen #(.HALF_W(HALF_W), .SRC_W(SW)) u_lo (
      .half_i (src[HALF_W-1:0]),
      .zext_i (zext),
      .wide_o (lo_res[s])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      vec_lane_sext #(.SRC_W(SW), .LANE_W(LANE_W)) u_sx (
        .elem_i (src[l*LANE_W +: SW]),
        .lane_o (sx_res[s][l*LANE_W +: LANE_W])
      );
    end
  end

  widen_op_e     op_e;
  logic          exc_d;
  logic [VW-1:0] sel_hi, sel_lo, sel_sx;
  logic [VW-1:0] res_d;

  assign op_e = widen_op_e'(op);

  always_comb begin
    sel_hi = '0;
    sel_lo = '0;
    sel_sx = '0;
    case (elem_sz)
      2'd0:    begin sel_hi = hi_res[0]; sel_lo = lo_res[0]; sel_sx = sx_res[0]; end
      2'd1:    begin sel_hi = hi_res[1]; sel_lo = lo_res[1]; sel_sx = sx_res[1]; end
      2'd2:    begin sel_hi = hi_res[2]; sel_lo = lo_res[2]; sel_sx = sx_res[2]; end
      default: ;
    endcase
  end

  always_comb begin
    exc_d = (elem_sz == 2'd3) || (op_e == OP_RSVD);
    res_d = '0;
    if (!exc_d) begin
      case (op_e)
        OP_WIDEN_HI: res_d = sel_hi;
        OP_WIDEN_LO: res_d = sel_lo;
        OP_LANE_SX:  res_d = sel_sx;
        default:     res_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      spec_exc <= 1'b0;
    end else begin
      result   <= res_d;
      spec_exc <= exc_d;
    end
  end
endmodule

// File: rtl/vec_widen_unit_chk.sv
module vec_widen_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [127:0] src,
  input logic [1:0]   op,
  input logic         zext,
  input logic [1:0]   elem_sz,
  input logic [127:0] result,
  input logic         spec_exc
);
  // R10: a raised flag never comes with data
  p_zero_on_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spec_exc |-> (result == '0));

  // R8: invalid size always flags
  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_sz == 2'd3) |=> spec_exc);

  // R9: reserved operation always flags
  p_rsvd_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3) |=> spec_exc);

  // R4 R6: logical byte widen-high puts element 0 into the low byte of halfword 0
  p_hi_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd0 && zext && elem_sz == 2'd0)
      |=> (result[127:120] == 8'h00 && result[119:112] == $past(src[127:120])));

  // R5 R6: arithmetic word widen-low sign-extends the last word
  p_lo_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd1 && !zext && elem_sz == 2'd2)
      |=> (result[63:0] == {{32{$past(src[31])}}, $past(src[31:0])}));

  // R7: lane sign-extend of bytes fills lane 0 with the sign of its low byte
  p_lane_sx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2 && elem_sz == 2'd0)
      |=> (result[127:64] == {{56{$past(src[71])}}, $past(src[71:64])}));

  // R2: valid request never flags on the following cycle
  p_no_false_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'd3 && elem_sz != 2'd3) |=> !spec_exc);
endmodule

bind vec_widen_unit vec_widen_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src      (src),
  .op       (op),
  .zext     (zext),
  .elem_sz  (elem_sz),
  .result   (result),
  .spec_exc (spec_exc)
);

// File: tb/vec_widen_unit_tb.sv
module vec_widen_unit_tb;
  logic         clk;
  logic         rst_n;
  logic [127:0] src;
  logic [1:0]   op;
  logic         zext;
  logic [1:0]   elem_sz;
  logic [127:0] result;
  logic         spec_exc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  vec_widen_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .op       (op),
    .zext     (zext),
    .elem_sz  (elem_sz),
    .result   (result),
    .spec_exc (spec_exc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [128:0] model(input logic [127:0] s, input logic [1:0] o,
                                         input logic lg, input logic [1:0] sz);
    logic [127:0] r;
    int w, nd, si, slsb, dlsb;
    r = '0;
    if (sz == 2'd3 || o == 2'd3) return {1'b1, 128'h0};
    w = 8 << sz;
    if (o == 2'd2) begin
      for (int k = 0; k < 2; k++)
        for (int b = 0; b < 64; b++)
          r[64*k+b] = (b < w) ? s[64*k+b] : s[64*k+w-1];
    end else begin
      nd = 64 / w;
      for (int d = 0; d < nd; d++) begin
        si   = (o == 2'd0) ? d : d + nd;
        slsb = 128 - (si + 1) * w;
        dlsb = 128 - (d + 1) * 2 * w;
        for (int b = 0; b < 2 * w; b++)
          r[dlsb+b] = (b < w) ? s[slsb+b] : (lg ? 1'b0 : s[slsb+w-1]);
      end
    end
    return {1'b0, r};
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic lg, input logic [1:0] sz);
    if (sz == 2'd3) return "R8 R10";
    if (o == 2'd3)  return "R9 R10";
    if (o == 2'd2)  return "R7 R3";
    if (o == 2'd0)  return lg ? "R4 R6 R3" : "R4 R3";
    return lg ? "R5 R6 R3" : "R5 R3";
  endfunction

  task automatic compare(input string req, input logic [128:0] exp);
    n_chk++;
    if ({spec_exc, result} !== exp) begin
      n_fail++;
      $display("FAIL %s: got exc=%0b res=%h expected exc=%0b res=%h",
               req, spec_exc, result, exp[128], exp[127:0]);
    end
  endtask

  // drive at negedge, compare at the following negedge (one register stage)
  task automatic apply(input logic [127:0] s, input logic [1:0] o,
                       input logic lg, input logic [1:0] sz);
    logic [128:0] exp;
    exp     = model(s, o, lg, sz);
    src     = s;
    op      = o;
    zext    = lg;
    elem_sz = sz;
    @(negedge clk);
    compare(tag_of(o, lg, sz), exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  logic [127:0] pat;

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n   = 1'b0;
    src     = {4{32'hdead_beef}};
    op      = 2'd0;
    zext    = 1'b0;
    elem_sz = 2'd0;
    repeat (3) @(negedge clk);
    compare("R1", 129'h0);
    rst_n = 1'b1;
    @(negedge clk);

    pat = 128'h80_7f_01_ff_02_fe_03_fd_84_45_86_47_88_49_8a_4b;
    for (int o = 0; o < 4; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int lg = 0; lg < 2; lg++)
          apply(pat, 2'(o), 1'(lg), 2'(sz));

    // R7: zext must not change lane sign-extend
    apply(128'h0000_0000_0000_0080_0000_0000_8000_0000, 2'd2, 1'b1, 2'd0);
    apply(128'h0000_0000_0000_0080_0000_0000_8000_0000, 2'd2, 1'b1, 2'd2);

    // R2: inputs change but output holds until the next edge
    apply(pat, 2'd0, 1'b1, 2'd0);
    src = ~pat; op = 2'd1; zext = 1'b0; elem_sz = 2'd1;
    #1;
    compare("R2", model(pat, 2'd0, 1'b1, 2'd0));
    @(negedge clk);
    compare("R2", model(~pat, 2'd1, 1'b0, 2'd1));

    // R10: exception after valid data clears the result
    apply({128{1'b1}}, 2'd1, 1'b0, 2'd2);
    apply({128{1'b1}}, 2'd3, 1'b0, 2'd1);
    apply({128{1'b1}}, 2'd0, 1'b1, 2'd3);

    for (int i = 0; i < 400; i++)
      apply({$urandom, $urandom, $urandom, $urandom}, 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule